// File: doc/BRIEF.md
# Sleep State Entry Arbiter

This block steps a system between the working state S0 and the sleep states S1, S3, S4 and S5. It also decides, every cycle, whether processor idle (Cx) entry or clock throttling may proceed. Software programs a sleep type and a go bit in one control write. A power-button override input forces the deepest state. A wake input brings the system back to S0, and a resume flag records that a sleep state was left. Software clears that flag by writing 1 to it.

A sleep request takes priority over both throttling and Cx entry. A pending or active sleep is the only thing that can hold thermal throttling off. Cx entry and sleep entry never overlap. The block has no streaming data path, so every pin is a plain control or status level. Writes are single-cycle strobes that need no handshake.

Top module: `sleep_seq_arb`

## Requirements
- R1: After reset, cur_state is 0 (S0), and entering, sleep_go, thr_en, cx_grant and resume_sts are all 0.
- R2: In S0, a control write with ctl_go=1 and a valid type sets sleep_go on the next edge. On the edge after that, entering rises and sleep_go self-clears. On the edge after that, cur_state shows the programmed type.
- R3: Sleep type codes 1, 3, 4 and 5 select S1, S3, S4 and S5, and cur_state uses the same codes. Codes 0, 2, 6 and 7 are reserved. A go write with a reserved code is a no-op: sleep_go stays 0 and the block stays in S0.
- R4: A power-button override in S0 or during entry makes the target S5 regardless of the programmed type. In S1, S3 or S4, it moves cur_state to 5 on the next edge. While the override is high, wake has no effect.
- R5: Wake while asleep returns cur_state to 0 on the next edge. Wake in S0 or during entry is ignored.
- R6: Leaving any sleep state sets resume_sts on the same edge. It stays 1 until a status write with sts_wr_resume=1. A status write with 0 has no effect. A set and a clear on the same edge leave the flag at 1.
- R7: thr_en is 1 when a thermal or software throttle request is high and no sleep is requested, pending or active. A sleep request, including one written in the current cycle, suppresses thermal throttling.
- R8: cx_grant follows cx_req in the same cycle, but only in S0 with no sleep requested, pending or active. It is never 1 together with entering, sleep_go or a nonzero cur_state.
- R9: Control writes made while the block is not in idle S0 (entering or asleep) are ignored and are not deferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_type | input | 3 | Sleep type code written with the strobe |
| ctl_go | input | 1 | Go bit written with the strobe |
| sts_wr | input | 1 | Status write strobe |
| sts_wr_resume | input | 1 | Value written to the resume flag (1 clears it) |
| pwrbtn_ovr | input | 1 | Power-button override |
| therm_req | input | 1 | Thermal throttle request |
| sw_thr_req | input | 1 | Software throttle request |
| cx_req | input | 1 | Processor idle entry request |
| wake | input | 1 | Wake event |
| cur_state | output | 3 | Current state code (0 = S0) |
| entering | output | 1 | Sleep entry in progress |
| sleep_go | output | 1 | Go bit readback, self-clearing |
| thr_en | output | 1 | Throttle enable |
| cx_grant | output | 1 | Cx entry granted |
| resume_sts | output | 1 | Resume status flag |

## Verification
A wrong phase or target register shows up within one or two edges as a wrong cur_state code, a missing entering cycle, or a sleep_go that does not self-clear. A stale target that ignores the override leaves cur_state at the programmed code. A wrong grant condition shows up in the same cycle as cx_grant or thr_en being high while a go write, pending go or entry is visible at the ports. A wrong resume flag shows up one edge after wake, or one edge after a status write.

// File: rtl/sleep_pkg.sv
package sleep_pkg;
  localparam int TYPE_W = 3;
  localparam logic [TYPE_W-1:0] CODE_S0 = 3'd0;
  localparam logic [TYPE_W-1:0] CODE_S5 = 3'd5;

  typedef enum logic [1:0] {
    PH_WORK  = 2'd0,
    PH_PEND  = 2'd1,
    PH_SLEEP = 2'd2
  } phase_e;

  // reserved codes (0, 2, 6, 7) are rejected
  function automatic logic type_ok(input logic [TYPE_W-1:0] t);
    return (t == 3'd1) || (t == 3'd3) || (t == 3'd4) || (t == 3'd5);
  endfunction
endpackage

// File: rtl/sleep_seq_fsm.sv
module sleep_seq_fsm
  import sleep_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [TYPE_W-1:0] ctl_type,
  input  logic              ctl_go,
  input  logic              pwrbtn_ovr,
  input  logic              wake,
  output phase_e            phase_o,
  output logic [TYPE_W-1:0] tgt_o,
  output logic              go_o,
  output logic              exit_o,
  output logic              sleep_req_o
);
  phase_e            phase_q, phase_d;
  logic [TYPE_W-1:0] tgt_q, tgt_d;
  logic              go_q, go_d;
  logic              new_req;

  assign new_req = (phase_q == PH_WORK) && ctl_wr && ctl_go && type_ok(ctl_type);
  assign exit_o  = (phase_q == PH_SLEEP) && wake && !pwrbtn_ovr;
  assign sleep_req_o = (phase_q != PH_WORK) || go_q || pwrbtn_ovr || new_req;

  always_comb begin
    phase_d = phase_q;
    tgt_d   = tgt_q;
    go_d    = go_q;
    unique case (phase_q)
      PH_WORK: begin
        if (pwrbtn_ovr) begin
          phase_d = PH_PEND;
          tgt_d   = CODE_S5;
          go_d    = 1'b0;
        end else if (go_q) begin
          phase_d = PH_PEND;
          go_d    = 1'b0;
        end else if (new_req) begin
          go_d  = 1'b1;
          tgt_d = ctl_type;
        end
      end
      PH_PEND: begin
        if (pwrbtn_ovr) tgt_d = CODE_S5;
        phase_d = PH_SLEEP;
      end
      PH_SLEEP: begin
        if (pwrbtn_ovr) tgt_d = CODE_S5;
        else if (wake) phase_d = PH_WORK;
      end
      default: phase_d = PH_WORK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_WORK;
      tgt_q   <= CODE_S0;
      go_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      tgt_q   <= tgt_d;
      go_q    <= go_d;
    end
  end

  assign phase_o = phase_q;
  assign tgt_o   = tgt_q;
  assign go_o    = go_q;

  // R2
  go_clears_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_PEND) |-> !go_q);

  // R3
  reserved_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_WORK && !go_q && !pwrbtn_ovr && ctl_wr && ctl_go && !type_ok(ctl_type))
      |=> (!go_q && phase_q == PH_WORK));

  // R4
  ovr_forces_s5_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SLEEP && pwrbtn_ovr) |=> (phase_q == PH_SLEEP && tgt_q == CODE_S5));

  // R5
  no_direct_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_WORK) |=> (phase_q != PH_SLEEP));
endmodule

// File: rtl/sleep_grant_arb.sv
module sleep_grant_arb #(
  parameter int N_THR = 2
) (
  input  logic             sleep_req,
  input  logic [N_THR-1:0] thr_src,
  input  logic             cx_req,
  output logic             thr_en,
  output logic             cx_grant
);
  logic [N_THR-1:0] thr_any;

  generate
    for (genvar i = 0; i < N_THR; i++) begin : g_or
      if (i == 0) begin : g_first
        assign thr_any[i] = thr_src[i];
      end else begin : g_rest
        assign thr_any[i] = thr_any[i-1] | thr_src[i];
      end
    end
  endgenerate

  assign thr_en   = thr_any[N_THR-1] && !sleep_req;
  assign cx_grant = cx_req && !sleep_req;
endmodule

// File: rtl/sleep_resume_flag.sv
module sleep_resume_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  // R6
  resume_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> (flag_q == $past(flag_q)));

  // R6
  resume_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q);
endmodule

// File: rtl/sleep_seq_arb.sv
module sleep_seq_arb
  import sleep_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [TYPE_W-1:0] ctl_type,
  input  logic              ctl_go,
  input  logic              sts_wr,
  input  logic              sts_wr_resume,
  input  logic              pwrbtn_ovr,
  input  logic              therm_req,
  input  logic              sw_thr_req,
  input  logic              cx_req,
  input  logic              wake,
  output logic [TYPE_W-1:0] cur_state,
  output logic              entering,
  output logic              sleep_go,
  output logic              thr_en,
  output logic              cx_grant,
  output logic              resume_sts
);
  localparam int N_THR = 2;

  phase_e            phase;
  logic [TYPE_W-1:0] tgt;
  logic              exit_p;
  logic              sleep_req;

  sleep_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_wr      (ctl_wr),
    .ctl_type    (ctl_type),
    .ctl_go      (ctl_go),
    .pwrbtn_ovr  (pwrbtn_ovr),
    .wake        (wake),
    .phase_o     (phase),
    .tgt_o       (tgt),
    .go_o        (sleep_go),
    .exit_o      (exit_p),
    .sleep_req_o (sleep_req)
  );

  sleep_grant_arb #(.N_THR(N_THR)) u_arb (
    .sleep_req (sleep_req),
    .thr_src   ({sw_thr_req, therm_req}),
    .cx_req    (cx_req),
    .thr_en    (thr_en),
    .cx_grant  (cx_grant)
  );

  sleep_resume_flag u_rsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (exit_p),
    .clr_i  (sts_wr && sts_wr_resume),
    .flag_o (resume_sts)
  );

  assign cur_state = (phase == PH_SLEEP) ? tgt : CODE_S0;
  assign entering  = (phase == PH_PEND);

  // R8
  cx_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cx_grant |-> (cur_state == CODE_S0 && !entering && !sleep_go));

  // R7
  thr_only_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    thr_en |-> (cur_state == CODE_S0 && !entering && !sleep_go));

  // R5
  resume_after_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resume_sts) |-> ($past(cur_state) != CODE_S0));
endmodule

// File: tb/sleep_seq_arb_tb_top.sv
module sleep_seq_arb_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 0, ctl_go = 0, sts_wr = 0, sts_wr_resume = 0;
  logic [2:0] ctl_type = 0;
  logic       pwrbtn_ovr = 0, therm_req = 0, sw_thr_req = 0, cx_req = 0, wake = 0;
  logic [2:0] cur_state;
  logic       entering, sleep_go, thr_en, cx_grant, resume_sts;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sleep_seq_arb dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_type(ctl_type), .ctl_go(ctl_go),
    .sts_wr(sts_wr), .sts_wr_resume(sts_wr_resume), .pwrbtn_ovr(pwrbtn_ovr),
    .therm_req(therm_req), .sw_thr_req(sw_thr_req), .cx_req(cx_req), .wake(wake),
    .cur_state(cur_state), .entering(entering), .sleep_go(sleep_go),
    .thr_en(thr_en), .cx_grant(cx_grant), .resume_sts(resume_sts)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ctl_write(input logic [2:0] t, input logic g);
    ctl_wr = 1; ctl_type = t; ctl_go = g;
    tick();
    ctl_wr = 0; ctl_go = 0;
  endtask

  task automatic clear_resume();
    sts_wr = 1; sts_wr_resume = 1;
    tick();
    sts_wr = 0; sts_wr_resume = 0;
  endtask

  task automatic t_reset();
    chk("R1", "cur_state", cur_state, 0);
    chk("R1", "entering", entering, 0);
    chk("R1", "sleep_go", sleep_go, 0);
    chk("R1", "thr_en", thr_en, 0);
    chk("R1", "cx_grant", cx_grant, 0);
    chk("R1", "resume_sts", resume_sts, 0);
  endtask

  task automatic t_enter_exit(input logic [2:0] t);
    therm_req = 1; cx_req = 1;
    ctl_wr = 1; ctl_type = t; ctl_go = 1;
    #1;
    chk("R8", "cx_grant on go write", cx_grant, 0);
    chk("R7", "thr_en on go write", thr_en, 0);
    tick();
    ctl_wr = 0; ctl_go = 0;
    chk("R2", "sleep_go after write", sleep_go, 1);
    chk("R2", "cur_state before entry", cur_state, 0);
    chk("R7", "thermal suppressed by go", thr_en, 0);
    chk("R8", "cx blocked by go", cx_grant, 0);
    tick();
    chk("R2", "entering", entering, 1);
    chk("R2", "sleep_go self-clear", sleep_go, 0);
    chk("R8", "cx blocked in entry", cx_grant, 0);
    tick();
    chk("R3", "cur_state code", cur_state, t);
    chk("R7", "thr_en asleep", thr_en, 0);
    chk("R8", "cx asleep", cx_grant, 0);
    wake = 1;
    tick();
    wake = 0;
    chk("R5", "back to S0", cur_state, 0);
    chk("R6", "resume set", resume_sts, 1);
    chk("R7", "thr_en back in S0", thr_en, 1);
    chk("R8", "cx back in S0", cx_grant, 1);
    sts_wr = 1; sts_wr_resume = 0;
    tick();
    sts_wr = 0;
    chk("R6", "write 0 no effect", resume_sts, 1);
    clear_resume();
    chk("R6", "W1C clears", resume_sts, 0);
    therm_req = 0; cx_req = 0;
  endtask

  task automatic t_reserved(input logic [2:0] t);
    therm_req = 1;
    ctl_write(t, 1);
    chk("R3", "reserved no go", sleep_go, 0);
    chk("R7", "throttle unaffected", thr_en, 1);
    tick();
    chk("R3", "reserved no entry", entering, 0);
    tick();
    chk("R3", "reserved stays S0", cur_state, 0);
    therm_req = 0;
  endtask

  task automatic t_override();
    ctl_write(3'd1, 1);
    pwrbtn_ovr = 1;
    tick();
    pwrbtn_ovr = 0;
    chk("R4", "ovr entry", entering, 1);
    tick();
    chk("R4", "ovr forces S5 over type 1", cur_state, 5);
    wake = 1; tick(); wake = 0;
    clear_resume();
    pwrbtn_ovr = 1;
    tick();
    pwrbtn_ovr = 0;
    tick();
    chk("R4", "ovr from S0", cur_state, 5);
    wake = 1; tick(); wake = 0;
    clear_resume();
    ctl_write(3'd3, 1);
    tick(); tick();
    chk("R4", "in S3", cur_state, 3);
    pwrbtn_ovr = 1; wake = 1;
    tick();
    pwrbtn_ovr = 0; wake = 0;
    chk("R4", "S3 to S5 under ovr", cur_state, 5);
    chk("R4", "wake masked by ovr", resume_sts, 0);
    wake = 1; tick(); wake = 0;
    chk("R5", "wake from S5", cur_state, 0);
    clear_resume();
  endtask

  task automatic t_wake_ignored();
    wake = 1; tick(); wake = 0;
    chk("R5", "wake in S0 ignored", cur_state, 0);
    chk("R5", "no resume from S0", resume_sts, 0);
    ctl_write(3'd4, 1);
    tick();
    wake = 1; tick(); wake = 0;
    chk("R5", "wake in entry ignored", cur_state, 4);
    wake = 1; tick(); wake = 0;
    clear_resume();
  endtask

  task automatic t_write_while_asleep();
    ctl_write(3'd1, 1);
    tick(); tick();
    chk("R9", "in S1", cur_state, 1);
    ctl_write(3'd4, 1);
    chk("R9", "go not set asleep", sleep_go, 0);
    chk("R9", "state kept", cur_state, 1);
    wake = 1; sts_wr = 1; sts_wr_resume = 1;
    tick();
    wake = 0; sts_wr = 0; sts_wr_resume = 0;
    chk("R6", "set wins over clear", resume_sts, 1);
    tick(); tick();
    chk("R9", "no deferred entry", cur_state, 0);
    chk("R9", "no deferred entering", entering, 0);
    clear_resume();
  endtask

  task automatic t_throttle();
    therm_req = 1; #1;
    chk("R7", "thermal alone", thr_en, 1);
    therm_req = 0; sw_thr_req = 1; #1;
    chk("R7", "software alone", thr_en, 1);
    sw_thr_req = 0; #1;
    chk("R7", "none", thr_en, 0);
    cx_req = 1; #1;
    chk("R8", "cx granted in S0", cx_grant, 1);
    pwrbtn_ovr = 1; #1;
    chk("R8", "cx blocked by ovr", cx_grant, 0);
    pwrbtn_ovr = 0; cx_req = 0;
    ctl_write(3'd2, 0);
    chk("R3", "go=0 write idle", sleep_go, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_throttle();
    t_enter_exit(3'd1);
    t_enter_exit(3'd3);
    t_enter_exit(3'd4);
    t_enter_exit(3'd5);
    t_reserved(3'd0);
    t_reserved(3'd2);
    t_reserved(3'd6);
    t_reserved(3'd7);
    t_override();
    t_wake_ignored();
    t_write_while_asleep();
    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule